// File: doc/BRIEF.md
# Egress Ones'-Complement Checksum Inserter

This block sits in the egress byte path and handles one transfer per command. A command gives the transfer length, a checksum enable, a start offset, a destination offset and a 16-bit seed. The block stores the transfer's bytes. While they arrive, it adds every byte from the start offset to the end of the transfer into a 16-bit ones'-complement sum. When the transfer is complete, it replays the stored bytes and puts the complemented sum at the destination position.

Both offsets are measured inside the current transfer. The start offset counts from the transfer's first byte. The destination offset counts from the start position. Pseudo-header words and any other protocol context are not built here. Software adds them into the seed before it issues the command. When the enable is clear, the stored bytes are replayed unchanged.

Top module: `csum_ins`

## Requirements
- R1: After reset the block accepts a command (`cmd_ready`=1), takes no stream byte (`s_ready`=0) and presents no output (`m_valid`=0).
- R2: The sum is a 16-bit ones'-complement addition with end-around carry. It covers bytes from offset `cmd_start` up to the last byte of the transfer. Counting from the start byte, the first byte of each pair is the upper 8 bits of a 16-bit word and the second byte is the lower 8 bits.
- R3: The seed enters the sum byte-swapped. Seed bits [7:0] share a lane with the byte at the start offset (the upper lane). Seed bits [15:8] share a lane with the byte at start+1.
- R4: With the enable set, output byte start+dest carries bits [15:8] of the complemented sum, and byte start+dest+1 carries bits [7:0]. When start+dest+1 lies past the end of the transfer, only the first of these two bytes is replaced. All other bytes leave unchanged.
- R5: When the covered span has an odd byte count, the final byte is summed in the upper lane and a zero fills the lower lane.
- R6: With the enable clear, the output bytes equal the input bytes in order.
- R7: Each command uses its own offsets and seed, measured from its own first byte. No state carries over from an earlier transfer.
- R8: No output byte is presented until the whole transfer has been accepted. `s_ready` and `m_valid` are never high together, and both are low while a command is awaited.
- R9: A transfer ends on the byte that brings the count to `cmd_len`, on an earlier byte with `s_last`, or on byte number MAX_BYTES. The output has the same number of bytes, and `m_last` is high on the final output byte only.
- R10: A command with `cmd_len` = 0 is consumed in one cycle. It takes no stream byte and produces no output byte.
- R11: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` hold their values into the next cycle.
- R12: A transfer of exactly MAX_BYTES bytes is stored and replayed with correct insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with `cmd_valid` |
| cmd_csum_en | input | 1 | Enable checksum insertion for this transfer |
| cmd_start | input | 8 | First covered byte, from the transfer's first byte |
| cmd_dest | input | 8 | Insertion position, counted from the start byte |
| cmd_seed | input | 16 | Initial sum value, network byte order |
| cmd_len | input | CNT_W | Transfer length in bytes (at most MAX_BYTES) |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted |
| s_data | input | 8 | Input byte |
| s_last | input | 1 | Input byte ends the transfer early |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Output byte taken |
| m_data | output | 8 | Output byte |
| m_last | output | 1 | Final output byte of the transfer |

## Verification
The bench builds the block with MAX_BYTES = 64, which makes CNT_W 7 bits. At that size a transfer that fills the whole store is short enough for a directed test. That test exercises the length-limit path and the highest store address. The small limit still allows long covered spans, so the bench can check all-ones data that forces repeated end-around carries. It also covers start offsets that leave the covered span even or odd, and insertion at the last byte, where the second checksum byte has no position to go to.

// File: rtl/csum_ins_pkg.sv
package csum_ins_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_DRAIN = 2'd2
    } ins_state_e;

endpackage

// File: rtl/csum_ins_adder.sv
// One ones'-complement accumulation step for a single byte.
module csum_ins_adder (
    input  logic [15:0] acc_i,
    input  logic [7:0]  byte_i,
    input  logic        hi_lane_i,
    output logic [15:0] acc_o
);
    logic [15:0] word;
    logic [16:0] raw;

    always_comb begin
        word  = hi_lane_i ? {byte_i, 8'h00} : {8'h00, byte_i};
        raw   = {1'b0, acc_i} + {1'b0, word};
        acc_o = raw[15:0] + {15'd0, raw[16]};
    end
endmodule

// File: rtl/csum_ins_store.sv
// Transfer byte store: one synchronous write port, one combinational read port.
module csum_ins_store #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/csum_ins.sv
module csum_ins
    import csum_ins_pkg::*;
#(
    parameter int MAX_BYTES = 256,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_csum_en,
    input  logic [7:0]       cmd_start,
    input  logic [7:0]       cmd_dest,
    input  logic [15:0]      cmd_seed,
    input  logic [CNT_W-1:0] cmd_len,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [7:0]       s_data,
    input  logic             s_last,
    output logic             m_valid,
    input  logic             m_ready,
    output logic [7:0]       m_data,
    output logic             m_last
);
    localparam int AW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
    localparam int PW = (CNT_W > 10) ? CNT_W : 10;
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_BYTES);

    typedef struct packed {
        ins_state_e       st;
        logic             en;
        logic [7:0]       start;
        logic [7:0]       dest;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] cnt;
        logic [15:0]      acc;
    } ins_ctl_t;

    ins_ctl_t ctl_d, ctl_q;

    logic        store_we;
    logic [7:0]  store_rdata;
    logic [15:0] acc_next;
    logic        hi_lane;
    logic        in_span;
    logic [CNT_W-1:0] cnt_inc;
    logic [PW-1:0]    cnt_x;
    logic [PW-1:0]    ins_pos;

    assign cnt_inc = ctl_q.cnt + ONE;
    assign cnt_x   = PW'(ctl_q.cnt);
    assign ins_pos = PW'(ctl_q.start) + PW'(ctl_q.dest);
    assign in_span = cnt_x >= PW'(ctl_q.start);
    // Counting from the start byte, even positions go to the upper lane.
    assign hi_lane = (ctl_q.cnt[0] == ctl_q.start[0]);

    csum_ins_adder u_adder (
        .acc_i     (ctl_q.acc),
        .byte_i    (s_data),
        .hi_lane_i (hi_lane),
        .acc_o     (acc_next)
    );

    csum_ins_store #(.DEPTH(MAX_BYTES), .AW(AW)) u_store (
        .clk     (clk),
        .we_i    (store_we),
        .waddr_i (ctl_q.cnt[AW-1:0]),
        .wdata_i (s_data),
        .raddr_i (ctl_q.cnt[AW-1:0]),
        .rdata_o (store_rdata)
    );

    always_comb begin
        ctl_d     = ctl_q;
        cmd_ready = 1'b0;
        s_ready   = 1'b0;
        m_valid   = 1'b0;
        m_last    = 1'b0;
        m_data    = store_rdata;
        store_we  = 1'b0;

        case (ctl_q.st)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid && (cmd_len != '0)) begin
                    ctl_d.st    = ST_FILL;
                    ctl_d.en    = cmd_csum_en;
                    ctl_d.start = cmd_start;
                    ctl_d.dest  = cmd_dest;
                    ctl_d.len   = cmd_len;
                    ctl_d.cnt   = '0;
                    // Network order: seed low byte sits in the start byte's lane.
                    ctl_d.acc   = {cmd_seed[7:0], cmd_seed[15:8]};
                end
            end
            ST_FILL: begin
                s_ready = 1'b1;
                if (s_valid) begin
                    store_we  = 1'b1;
                    ctl_d.cnt = cnt_inc;
                    if (ctl_q.en && in_span) begin
                        ctl_d.acc = acc_next;
                    end
                    if (s_last || (cnt_inc == ctl_q.len) || (cnt_inc == LIMIT)) begin
                        ctl_d.len = cnt_inc;
                        ctl_d.cnt = '0;
                        ctl_d.st  = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                m_valid = 1'b1;
                m_last  = (cnt_inc == ctl_q.len);
                if (ctl_q.en) begin
                    if (cnt_x == ins_pos) begin
                        m_data = ~ctl_q.acc[15:8];
                    end else if (cnt_x == ins_pos + PW'(1)) begin
                        m_data = ~ctl_q.acc[7:0];
                    end
                end
                if (m_ready) begin
                    ctl_d.cnt = cnt_inc;
                    if (cnt_inc == ctl_q.len) begin
                        ctl_d.cnt = '0;
                        ctl_d.st  = ST_IDLE;
                    end
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/csum_ins_chk.sv
module csum_ins_chk #(
    parameter int CW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [CW-1:0] cmd_len,
    input logic          s_ready,
    input logic          m_valid,
    input logic          m_ready,
    input logic [7:0]    m_data,
    input logic          m_last
);
    // R8: input and output phases never overlap
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_ready && m_valid));

    // R8: while a command is awaited nothing else moves
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!s_ready && !m_valid));

    // R9: end marker only on a presented byte
    p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        m_last |-> m_valid);

    // R10: an empty command leaves the block awaiting the next command
    p_empty_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_len == '0)) |=> cmd_ready);

    // R11: stalled output holds
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));
endmodule

bind csum_ins csum_ins_chk #(.CW(CNT_W)) u_csum_ins_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_len   (cmd_len),
    .s_ready   (s_ready),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_data    (m_data),
    .m_last    (m_last)
);

// File: tb/csum_ins_tb_top.sv
module csum_ins_tb_top;
    localparam int MAXB = 64;
    localparam int CW   = $clog2(MAXB + 1);

    typedef struct packed {
        bit        en;
        bit [7:0]  start;
        bit [7:0]  dest;
        bit [15:0] seed;
        bit [7:0]  size;
        bit [7:0]  lastat;   // index of the s_last byte; 255 = at size-1
        bit [7:0]  pat;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'd0,  8'd2, 16'h0000, 8'd8,  8'd255, 8'd1},  // R2 plain sum
        '{1'b1, 8'd3,  8'd0, 16'h1234, 8'd10, 8'd255, 8'd2},  // R3 seed lanes, R7 offset from own first byte
        '{1'b1, 8'd0,  8'd1, 16'h0001, 8'd7,  8'd255, 8'd3},  // R5 odd span
        '{1'b0, 8'd0,  8'd0, 16'h0000, 8'd12, 8'd255, 8'd4},  // R6 pass-through
        '{1'b1, 8'd2,  8'd1, 16'hABCD, 8'd8,  8'd5,   8'd5},  // R9 early end
        '{1'b1, 8'd0,  8'd5, 16'h00FF, 8'd6,  8'd255, 8'd6},  // R4 insertion at last byte
        '{1'b1, 8'd20, 8'd1, 16'hFFFF, 8'd30, 8'd255, 8'd0},  // R2 carry chain
        '{1'b1, 8'd1,  8'd3, 16'h8001, 8'd9,  8'd255, 8'd7}   // R7 second offset pair
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic          cmd_csum_en = 1'b0;
    logic [7:0]    cmd_start = '0;
    logic [7:0]    cmd_dest = '0;
    logic [15:0]   cmd_seed = '0;
    logic [CW-1:0] cmd_len = '0;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic [7:0]    s_data = '0;
    logic          s_last = 1'b0;
    logic          m_valid;
    logic          m_ready = 1'b0;
    logic [7:0]    m_data;
    logic          m_last;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] in_b  [MAXB];
    logic [7:0] exp_b [MAXB];
    logic [7:0] got_b [MAXB];

    always #2.5 clk = ~clk;

    csum_ins #(.MAX_BYTES(MAXB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_csum_en(cmd_csum_en),
        .cmd_start(cmd_start), .cmd_dest(cmd_dest), .cmd_seed(cmd_seed), .cmd_len(cmd_len),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat_byte(input logic [7:0] pat, input int i);
        if (pat == 8'd0) return 8'hFF;
        return 8'(pat * 7 + i * 37 + (i >> 3));
    endfunction

    // Independent model of the expected output bytes.
    function automatic void model(input bit en, input int start, input int dest,
                                  input logic [15:0] seed, input int len);
        logic [15:0] acc;
        logic [16:0] raw;
        logic [15:0] w;
        acc = {seed[7:0], seed[15:8]};
        for (int i = start; i < len; i++) begin
            w   = (((i - start) % 2) == 0) ? {in_b[i], 8'h00} : {8'h00, in_b[i]};
            raw = {1'b0, acc} + {1'b0, w};
            acc = raw[15:0] + {15'd0, raw[16]};
        end
        for (int i = 0; i < len; i++) exp_b[i] = in_b[i];
        if (en) begin
            if (start + dest < len)     exp_b[start + dest]     = ~acc[15:8];
            if (start + dest + 1 < len) exp_b[start + dest + 1] = ~acc[7:0];
        end
    endfunction

    task automatic send_cmd(input bit en, input logic [7:0] st, input logic [7:0] ds,
                            input logic [15:0] sd, input int len);
        @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_csum_en = en;
        cmd_start   = st;
        cmd_dest    = ds;
        cmd_seed    = sd;
        cmd_len     = CW'(len);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_bytes(input int n, input int lastat, inout bit early_out);
        for (int i = 0; i < n; i++) begin
            if ((i % 4) == 3) begin
                s_valid = 1'b0;
                if (m_valid) early_out = 1'b1;
                @(negedge clk);
            end
            s_valid = 1'b1;
            s_data  = in_b[i];
            s_last  = (i == lastat);
            while (!s_ready) begin
                if (m_valid) early_out = 1'b1;
                @(negedge clk);
            end
            if (m_valid) early_out = 1'b1;
            @(negedge clk);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic run_xfer(input bit en, input int st, input int ds, input logic [15:0] sd,
                            input int size, input int lastat, input logic [7:0] pat,
                            input string req);
        int  len;
        int  n;
        int  guard;
        bit  early_out;
        bit  hold_ok;
        bit  last_ok;
        bit  excl_ok;
        bit  pend;
        bit  done;
        int  bad_idx;
        logic [7:0] held;
        len = (lastat < size) ? lastat + 1 : size;
        if (len > MAXB) len = MAXB;
        for (int i = 0; i < MAXB; i++) in_b[i] = pat_byte(pat, i);
        model(en, st, ds, sd, len);
        early_out = 1'b0;
        send_cmd(en, 8'(st), 8'(ds), sd, size);
        send_bytes(len, (lastat < size) ? lastat : size - 1, early_out);
        check(!early_out, "R8", "output before transfer complete", int'(early_out), 0);

        n = 0; guard = 0; hold_ok = 1; last_ok = 1; excl_ok = 1; pend = 0; done = 0;
        while (!done && guard < 600) begin
            if (pend) begin
                if (!(m_valid && m_data == held)) hold_ok = 0;
                pend = 0;
            end
            if (s_ready) excl_ok = 0;
            m_ready = ((guard % 3) != 1);
            if (m_valid) begin
                if (m_ready) begin
                    if (n < MAXB) got_b[n] = m_data;
                    if (m_last != (n == len - 1)) last_ok = 0;
                    n++;
                    if (m_last) done = 1;
                end else begin
                    held = m_data;
                    pend = 1;
                end
            end
            @(negedge clk);
            guard++;
        end
        m_ready = 1'b0;
        check(n == len && last_ok, "R9", "output length / end marker", n, len);
        check(hold_ok, "R11", "stalled output not held", int'(hold_ok), 1);
        check(excl_ok, "R8", "input ready during replay", int'(excl_ok), 1);
        bad_idx = -1;
        for (int i = 0; i < len && i < n; i++) begin
            if (bad_idx < 0 && got_b[i] !== exp_b[i]) bad_idx = i;
        end
        if (bad_idx < 0) check(1'b1, req, "data", 0, 0);
        else check(1'b0, req, $sformatf("data byte %0d", bad_idx),
                   int'(got_b[bad_idx]), int'(exp_b[bad_idx]));
    endtask

    function automatic string row_tag(input int idx);
        case (idx)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            3: return "R6";
            4: return "R9";
            5: return "R4";
            6: return "R2";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cmd_ready == 1'b1 && s_ready == 1'b0 && m_valid == 1'b0, "R1",
              "reset handshake state", {cmd_ready, s_ready, m_valid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1 && s_ready == 1'b0 && m_valid == 1'b0, "R1",
              "state after reset release", {cmd_ready, s_ready, m_valid}, 3'b100);

        for (int v = 0; v < NV; v++) begin
            run_xfer(VECS[v].en, int'(VECS[v].start), int'(VECS[v].dest), VECS[v].seed,
                     int'(VECS[v].size),
                     (VECS[v].lastat == 8'd255) ? 1000 : int'(VECS[v].lastat),
                     VECS[v].pat, row_tag(v));
        end

        // R10: empty command
        send_cmd(1'b1, 8'd0, 8'd0, 16'h5555, 0);
        for (int k = 0; k < 4; k++) begin
            check(cmd_ready && !s_ready && !m_valid, "R10", "empty command state",
                  {cmd_ready, s_ready, m_valid}, 3'b100);
            @(negedge clk);
        end
        run_xfer(1'b1, 0, 2, 16'h0000, 4, 1000, 8'd9, "R10");

        // R12: full store
        run_xfer(1'b1, 0, 62, 16'h4321, MAXB, 1000, 8'd11, "R12");
        // R4: second byte past the end of a full transfer
        run_xfer(1'b1, 5, 58, 16'h0F0F, MAXB, 1000, 8'd13, "R4");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule